// File: doc/BRIEF.md
# Control-Transfer Resolution and State-Count Decoder

This block sits in the decode stage of a sequencer for an 8-bit accumulator processor. It takes the current opcode byte together with the sign, zero, parity and carry flags and decides, within the same cycle, four things. The first is whether the byte is a control transfer at all. The second is which kind it is: a jump, a call, a return or a restart. The third is whether the transfer is taken. The fourth is how many clock states the instruction will consume given that outcome. For restarts it also produces the fixed vector address.

The block is purely combinational. The sequencer feeds the opcode in once the byte has been fetched. It uses the taken output to choose the next program counter source, and it loads the state count into its timing counter. Program counter updates, stack memory traffic and operand fetch stay in the sequencer.

Top module: `xfer_decode`

## Requirements
- R1: The condition field is opcode bits 5:3. Its codes are 000 = zero flag clear, 001 = zero flag set, 010 = carry clear, 011 = carry set, 100 = parity flag clear (odd), 101 = parity flag set (even), 110 = sign clear (plus) and 111 = sign set (minus). A conditional transfer is taken exactly when its coded condition holds.
- R2: Opcodes of the form 11ccc000 are conditional returns (kind_o = 3), 11ccc010 are conditional jumps (kind_o = 1) and 11ccc100 are conditional calls (kind_o = 2). The kind codes are 0 = none, 1 = jump, 2 = call, 3 = return and 4 = restart.
- R3: The unconditional forms are always taken. 0xC3 is a jump costing 10 states, 0xCD is a call costing 18, 0xC9 is a return costing 10, and 0xE9 (jump to the address held in HL) is a jump costing 6.
- R4: Opcodes 11nnn111 are restarts (kind_o = 4). They are always taken, cost 12 states and report vector_o = nnn × 8, which ranges from 0x0000 to 0x0038.
- R5: A conditional jump reports 10 states when taken and 7 when not taken.
- R6: A conditional call reports 18 states when taken and 9 when not taken.
- R7: A conditional return reports 12 states when taken and 6 when not taken.
- R8: Any opcode that is not a control transfer reports kind_o = 0, taken_o = 0, states_o = 0 and vector_o = 0, whatever the flags.
- R9: vector_o is 0 for every opcode except a restart.
- R10: is_xfer_o is 1 exactly when kind_o is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 8 | Opcode byte under decode |
| flag_sign_i | input | 1 | Sign flag |
| flag_zero_i | input | 1 | Zero flag |
| flag_par_i | input | 1 | Parity flag (1 = even) |
| flag_carry_i | input | 1 | Carry flag |
| is_xfer_o | output | 1 | Opcode is a control transfer |
| kind_o | output | 3 | Transfer kind code (0 none, 1 jump, 2 call, 3 return, 4 restart) |
| taken_o | output | 1 | Transfer is taken with the present flags |
| vector_o | output | 16 | Restart vector address, 0 otherwise |
| states_o | output | 5 | Clock states the instruction consumes for this outcome |

## Verification
The embedded checks watch the invariants that must hold for every opcode and flag combination. Non-transfers stay quiet. The transfer flag agrees with the kind code. A restart vector is always aligned to 8 bytes and lies below 0x40. The conditional forms decode only to jump, call or return. Each pair of complementary conditions never agrees. The exact cost of each taken and not-taken case, the mapping of each condition code to its flag, and the full opcode-to-kind map can only be shown by the bench. To do this it sweeps all 256 opcodes against all 16 flag patterns and compares every output with an independently written model.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    XK_NONE = 3'd0,
    XK_JUMP = 3'd1,
    XK_CALL = 3'd2,
    XK_RET  = 3'd3,
    XK_RST  = 3'd4
  } xkind_e;

  // Truth of one condition code against the flags.
  function automatic logic flag_cond_met(input logic [2:0] cc,
                                         input logic s, input logic z,
                                         input logic p, input logic cy);
    logic sel;
    unique case (cc[2:1])
      2'b00:   sel = z;
      2'b01:   sel = cy;
      2'b10:   sel = p;
      default: sel = s;
    endcase
    // Even codes test for the flag being clear, odd codes for set.
    return cc[0] ? sel : ~sel;
  endfunction

  // Restart target: slot number scaled by the 8-byte slot size.
  function automatic logic [15:0] rst_vector(input logic [2:0] slot);
    return {10'b0, slot, 3'b000};
  endfunction

endpackage

// File: rtl/xfer_opclass.sv
module xfer_opclass
  import xfer_pkg::*;
(
  input  logic [7:0] op_i,
  output xkind_e     kind_o,
  output logic       cond_form_o,
  output logic       hl_target_o,
  output logic [2:0] field_o
);

  logic       top_pair;
  logic [2:0] low3;

  assign top_pair = (op_i[7:6] == 2'b11);
  assign low3     = op_i[2:0];
  assign field_o  = op_i[5:3];

  always_comb begin
    kind_o      = XK_NONE;
    cond_form_o = 1'b0;
    hl_target_o = 1'b0;
    if (top_pair) begin
      unique case (low3)
        3'b000: begin
          kind_o      = XK_RET;
          cond_form_o = 1'b1;
        end
        3'b001: begin
          if (field_o == 3'b001) begin
            kind_o = XK_RET;
          end else if (field_o == 3'b101) begin
            kind_o      = XK_JUMP;
            hl_target_o = 1'b1;
          end
        end
        3'b010: begin
          kind_o      = XK_JUMP;
          cond_form_o = 1'b1;
        end
        3'b011: begin
          if (field_o == 3'b000) kind_o = XK_JUMP;
        end
        3'b100: begin
          kind_o      = XK_CALL;
          cond_form_o = 1'b1;
        end
        3'b101: begin
          if (field_o == 3'b001) kind_o = XK_CALL;
        end
        3'b111: kind_o = XK_RST;
        default: kind_o = XK_NONE;
      endcase
    end
  end

  // A conditional form may only be a jump, call or return.
  always_comb begin
    p_cond_form_kind_r2: assert (!cond_form_o ||
      (kind_o == XK_JUMP || kind_o == XK_CALL || kind_o == XK_RET))
      else $error("conditional form decoded to kind %0d", kind_o);
  end

endmodule

// File: rtl/xfer_cond_eval.sv
module xfer_cond_eval
  import xfer_pkg::*;
#(
  parameter int N_COND = 8
) (
  input  logic [2:0] cc_i,
  input  logic       s_i,
  input  logic       z_i,
  input  logic       p_i,
  input  logic       cy_i,
  output logic       met_o
);

  localparam int N_PAIRS = N_COND / 2;

  logic [N_COND-1:0] lane;

  // One evaluation lane per condition code.
  for (genvar g = 0; g < N_COND; g++) begin : g_lane
    assign lane[g] = flag_cond_met(3'(g), s_i, z_i, p_i, cy_i);
  end

  assign met_o = lane[cc_i];

  // Codes 2k and 2k+1 test the same flag with opposite sense.
  always_comb begin
    for (int k = 0; k < N_PAIRS; k++) begin
      p_cond_pair_r1: assert (lane[2*k] != lane[2*k+1])
        else $error("condition pair %0d agrees", k);
    end
  end

endmodule

// File: rtl/xfer_cost_table.sv
module xfer_cost_table
  import xfer_pkg::*;
#(
  parameter int ST_W          = 5,
  parameter int COST_JMP_T    = 10,
  parameter int COST_JMP_N    = 7,
  parameter int COST_CALL_T   = 18,
  parameter int COST_CALL_N   = 9,
  parameter int COST_RET_T    = 12,
  parameter int COST_RET_N    = 6,
  parameter int COST_JMP_U    = 10,
  parameter int COST_CALL_U   = 18,
  parameter int COST_RET_U    = 10,
  parameter int COST_HL_JMP   = 6,
  parameter int COST_RST      = 12
) (
  input  xkind_e          kind_i,
  input  logic            cond_form_i,
  input  logic            hl_target_i,
  input  logic            taken_i,
  output logic [ST_W-1:0] states_o
);

  function automatic logic [ST_W-1:0] pick(input logic t, input int ct, input int cn);
    return t ? ST_W'(ct) : ST_W'(cn);
  endfunction

  always_comb begin
    unique case (kind_i)
      XK_JUMP: begin
        if (hl_target_i)      states_o = ST_W'(COST_HL_JMP);
        else if (cond_form_i) states_o = pick(taken_i, COST_JMP_T, COST_JMP_N);
        else                  states_o = ST_W'(COST_JMP_U);
      end
      XK_CALL: states_o = cond_form_i ? pick(taken_i, COST_CALL_T, COST_CALL_N)
                                      : ST_W'(COST_CALL_U);
      XK_RET:  states_o = cond_form_i ? pick(taken_i, COST_RET_T, COST_RET_N)
                                      : ST_W'(COST_RET_U);
      XK_RST:  states_o = ST_W'(COST_RST);
      default: states_o = '0;
    endcase
  end

  // A transfer always costs something; a non-transfer reports nothing.
  always_comb begin
    p_cost_presence_r8: assert ((kind_i == XK_NONE) == (states_o == '0))
      else $error("cost %0d for kind %0d", states_o, kind_i);
  end

endmodule

// File: rtl/xfer_decode.sv
module xfer_decode
  import xfer_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter int ST_W  = 5
) (
  input  logic [7:0]       op_i,
  input  logic             flag_sign_i,
  input  logic             flag_zero_i,
  input  logic             flag_par_i,
  input  logic             flag_carry_i,
  output logic             is_xfer_o,
  output logic [2:0]       kind_o,
  output logic             taken_o,
  output logic [VEC_W-1:0] vector_o,
  output logic [ST_W-1:0]  states_o
);

  localparam int SLOT_SPAN = 8 * 8;

  xkind_e     kind;
  logic       cond_form;
  logic       hl_target;
  logic [2:0] field;
  logic       cond_met;
  logic       is_rst;
  logic       is_known;

  xfer_opclass u_class (
    .op_i        (op_i),
    .kind_o      (kind),
    .cond_form_o (cond_form),
    .hl_target_o (hl_target),
    .field_o     (field)
  );

  xfer_cond_eval #(.N_COND(8)) u_cond (
    .cc_i  (field),
    .s_i   (flag_sign_i),
    .z_i   (flag_zero_i),
    .p_i   (flag_par_i),
    .cy_i  (flag_carry_i),
    .met_o (cond_met)
  );

  assign is_known = (kind != XK_NONE);
  assign is_rst   = (kind == XK_RST);
  assign taken_o  = is_known && (!cond_form || cond_met);

  xfer_cost_table #(.ST_W(ST_W)) u_cost (
    .kind_i      (kind),
    .cond_form_i (cond_form),
    .hl_target_i (hl_target),
    .taken_i     (taken_o),
    .states_o    (states_o)
  );

  assign is_xfer_o = is_known;
  assign kind_o    = kind;
  assign vector_o  = is_rst ? VEC_W'(rst_vector(field)) : '0;

  always_comb begin
    p_quiet_none_r8: assert (is_xfer_o || (!taken_o && vector_o == '0))
      else $error("non-transfer drives taken or vector");
    p_xfer_vs_kind_r10: assert (is_xfer_o == (kind_o != 3'd0))
      else $error("transfer flag disagrees with kind %0d", kind_o);
    p_rst_vector_r4: assert (kind_o != 3'd4 ||
      (taken_o && vector_o[2:0] == 3'b000 && int'(vector_o) < SLOT_SPAN))
      else $error("bad restart vector %h", vector_o);
    p_vector_only_rst_r9: assert (kind_o == 3'd4 || vector_o == '0)
      else $error("vector %h outside restart", vector_o);
    p_uncond_taken_r3: assert (!(op_i == 8'hC3 || op_i == 8'hCD ||
                                 op_i == 8'hC9 || op_i == 8'hE9) || taken_o)
      else $error("unconditional %h not taken", op_i);
  end

endmodule

// File: tb/test_xfer_decode.sv
module test_xfer_decode;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  op;
  logic        fs, fz, fp, fc;
  logic        is_xfer, taken;
  logic [2:0]  kind;
  logic [15:0] vec;
  logic [4:0]  states;

  int checks = 0;
  int errs   = 0;
  bit driver_done = 1'b0;

  typedef struct {
    logic [7:0]  op;
    logic [3:0]  flags;
    logic        x;
    logic [2:0]  k;
    logic        t;
    logic [15:0] v;
    logic [4:0]  st;
    string       req;
  } item_t;

  item_t sb[$];

  always #5 clk = ~clk;

  xfer_decode i_xfer_decode (
    .op_i         (op),
    .flag_sign_i  (fs),
    .flag_zero_i  (fz),
    .flag_par_i   (fp),
    .flag_carry_i (fc),
    .is_xfer_o    (is_xfer),
    .kind_o       (kind),
    .taken_o      (taken),
    .vector_o     (vec),
    .states_o     (states)
  );

  // Reference model written from the requirements.
  function automatic item_t model(input logic [7:0] o, input logic [3:0] f);
    item_t e;
    logic s, z, p, c, ok;
    s = f[3]; z = f[2]; p = f[1]; c = f[0];
    e.op = o; e.flags = f;
    e.x = 0; e.k = 0; e.t = 0; e.v = 0; e.st = 0; e.req = "R8";
    // R1: condition code mapping
    case (o[5:3])
      3'd0: ok = !z;
      3'd1: ok = z;
      3'd2: ok = !c;
      3'd3: ok = c;
      3'd4: ok = !p;
      3'd5: ok = p;
      3'd6: ok = !s;
      default: ok = s;
    endcase
    if (o == 8'hC3)      begin e.k = 1; e.t = 1; e.st = 10; e.req = "R3"; end
    else if (o == 8'hCD) begin e.k = 2; e.t = 1; e.st = 18; e.req = "R3"; end
    else if (o == 8'hC9) begin e.k = 3; e.t = 1; e.st = 10; e.req = "R3"; end
    else if (o == 8'hE9) begin e.k = 1; e.t = 1; e.st = 6;  e.req = "R3"; end
    else if (o[7:6] == 2'b11) begin
      case (o[2:0])
        3'd2: begin e.k = 1; e.t = ok; e.st = ok ? 10 : 7;  e.req = "R5/R2/R1"; end
        3'd4: begin e.k = 2; e.t = ok; e.st = ok ? 18 : 9;  e.req = "R6/R2/R1"; end
        3'd0: begin e.k = 3; e.t = ok; e.st = ok ? 12 : 6;  e.req = "R7/R2/R1"; end
        3'd7: begin e.k = 4; e.t = 1; e.st = 12; e.v = 16'(o[5:3]) * 16'd8; e.req = "R4"; end
        default: ;
      endcase
    end
    e.x = (e.k != 0);
    return e;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp, input logic [7:0] o);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s op=%h actual=%h expected=%h", req, what, o, act, exp);
    end
  endtask

  // Driver: apply stimulus on the falling edge, push the expectation.
  task automatic drive(input logic [7:0] o, input logic [3:0] f);
    @(negedge clk);
    op = o; {fs, fz, fp, fc} = f;
    sb.push_back(model(o, f));
  endtask

  // Monitor: on each rising edge, inputs have been stable for half a cycle.
  initial begin
    forever begin
      @(posedge clk);
      if (sb.size() > 0) begin
        item_t e;
        e = sb.pop_front();
        check("R10", "is_xfer", 16'(is_xfer), 16'(e.x), e.op);
        check(e.req, "kind",    16'(kind),    16'(e.k), e.op);
        check(e.req, "taken",   16'(taken),   16'(e.t), e.op);
        check(e.k == 4 ? "R4" : "R9", "vector", vec, e.v, e.op);
        check(e.req, "states",  16'(states),  16'(e.st), e.op);
      end
    end
  end

  initial begin
    op = 8'h00; {fs, fz, fp, fc} = 4'h0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle state with a no-operation byte: R8
    drive(8'h00, 4'h0);
    // Directed: R1 jump-if-not-zero taken and not taken (R5)
    drive(8'hC2, 4'b0000);
    drive(8'hC2, 4'b0100);
    // R6 call-on-minus, R7 return-on-parity-even
    drive(8'hFC, 4'b1000);
    drive(8'hE8, 4'b0000);
    // R4 highest restart slot
    drive(8'hFF, 4'hF);
    // R3 hl-indirect jump
    drive(8'hE9, 4'h0);
    // Full sweep of opcodes against flag patterns
    for (int o = 0; o < 256; o++) begin
      for (int f = 0; f < 16; f++) begin
        drive(8'(o), 4'(f));
      end
    end
    @(negedge clk);
    repeat (3) @(posedge clk);
    driver_done = 1'b1;
  end

  initial begin
    fork
      wait (driver_done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule